// File: doc/BRIEF.md
# Countdown Watchdog Timer with Word Register Interface

This block is a countdown watchdog for a larger chip. Software programs a reload value and a control word through a simple 32-bit, word-aligned register port. It keeps the timer alive by writing a fixed 16-bit key, which copies the reload value into the live counter. While enabled, the counter steps down by one on every tick. The tick is either every clock cycle or a 1 MHz tick that a parameterised divider derives from the clock.

When the counter sits at zero while the timer is armed and enabled, the block raises a one-cycle expiry pulse. It also raises a one-cycle interrupt pulse, a system-reset pulse and an external-reset pulse, each only when its control bit allows it, plus a scope flag for a full-chip reset. After firing, the timer stays quiet until software writes the key or enables it again.

A hold input marks the memory controller as being in reset. While it is high, an expiry produces no pulses and wipes the control word.

Top module: `tick_watchdog`

## Requirements
- R1: Register read values use byte addresses. Address 0x00 returns the live counter and ignores writes. Address 0x04 is the read/write reload value. Address 0x08 always reads 0. Address 0x0C returns the 6-bit control word in bits [5:0]. Control bit 0 is enable, bit 1 system reset, bit 2 interrupt, bit 3 external reset, bit 4 tick select and bit 5 full-chip scope.
- R2: A write to 0x08 whose bits [15:0] equal 0x4755 copies the reload value into the counter and arms the timer, whatever bits [31:16] hold. Any other value leaves the counter unchanged.
- R3: A control write that raises bit 0 from 0 to 1 loads the reload value into the counter, arms the timer and starts counting.
- R4: A control write that clears bit 0 freezes the counter. A control write that keeps bit 0 at 1 updates the other bits and does not reload the counter.
- R5: With bit 4 clear, the counter steps down once per clock cycle. With bit 4 set, it steps down once per CLK_HZ/TICK_HZ cycles, and the divider restarts at each reload.
- R6: After a reload of value N at a clock edge, expire_o is high for exactly one cycle, N*M+1 edges later. M is 1 for the clock tick and CLK_HZ/TICK_HZ for the 1 MHz tick.
- R7: irq_o, sysrst_o and extrst_o pulse together with expire_o only when control bits 2, 1 and 3 are set. fullchip_o pulses with sysrst_o only when bit 5 is set.
- R8: After reset, the counter and the reload value both read 0x03EF1480, the control word reads 0 and all outputs are low.
- R9: If mem_hold is high when the counter expires, no output pulses and the control word becomes 0.
- R10: After an expiry, the counter stays at 0 and no further pulse occurs until a key write or an enable rise.
- R11: Accesses to unmapped or misaligned addresses read 0, and writes to them change no register.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| mem_hold | input | 1 | Memory controller in reset: suppresses expiry |
| expire_o | output | 1 | One-cycle expiry pulse |
| irq_o | output | 1 | Interrupt pulse |
| sysrst_o | output | 1 | System-reset request pulse |
| extrst_o | output | 1 | External-reset request pulse |
| fullchip_o | output | 1 | Reset scope is the full chip (with sysrst_o) |

## Verification
Every cycle, the bound checker confirms several properties:
- expiry is a single-cycle pulse;
- the gated pulses never appear without it;
- no pulse follows a cycle with mem_hold high;
- a counter at zero stays at zero unless software writes;
- the clock-rate tick decrements by exactly one;
- a disabled counter never moves without a key write or an enable write.

The exact expiry latency for both tick sources, the key matching and the retention of the control bits can only be shown by the bench's scenarios. The same holds for the control word being wiped under mem_hold and for unmapped accesses being ignored.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
   localparam int unsigned DATA_W   = 32;
   localparam int unsigned CTRL_W   = 6;
   localparam logic [15:0] KICK_KEY = 16'h4755;
   localparam logic [31:0] POR_COUNT = 32'h03EF_1480;

   // word indices of the registers
   localparam int unsigned W_COUNT  = 0;
   localparam int unsigned W_RELOAD = 1;
   localparam int unsigned W_KICK   = 2;
   localparam int unsigned W_CTRL   = 3;

   // control word, bit 0 at the bottom
   typedef struct packed {
      logic full_chip;   // bit 5
      logic tick_slow;   // bit 4
      logic ext_en;      // bit 3
      logic irq_en;      // bit 2
      logic sys_en;      // bit 1
      logic enable;      // bit 0
   } ctrl_t;
endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
   parameter int unsigned DIV = 50
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   input  logic clear_i,
   output logic tick_o
);
   localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;

   if (DIV < 1) begin : g_bad_div
      $error("wdog_prescaler: DIV must be at least 1");
   end

   if (DIV == 1) begin : g_pass
      assign tick_o = run_i;
   end else begin : g_div
      localparam logic [PW-1:0] LAST = PW'(DIV - 1);
      logic [PW-1:0] pcnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pcnt_q <= '0;
         end else if (clear_i || !run_i) begin
            pcnt_q <= '0;
         end else if (pcnt_q == LAST) begin
            pcnt_q <= '0;
         end else begin
            pcnt_q <= pcnt_q + 1'b1;
         end
      end

      assign tick_o = run_i && (pcnt_q == LAST);
   end
endmodule

// File: rtl/wdog_core.sv
module wdog_core #(
   parameter int unsigned CNT_W   = 32,
   parameter logic [CNT_W-1:0] POR_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic             step_i,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   input  logic             hold_i,
   input  logic             irq_en_i,
   input  logic             sys_en_i,
   input  logic             ext_en_i,
   input  logic             full_en_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             armed_o,
   output logic             quash_o,
   output logic             expire_o,
   output logic             irq_o,
   output logic             sysrst_o,
   output logic             extrst_o,
   output logic             fullchip_o
);
   logic [CNT_W-1:0] cnt_q;
   logic             armed_q;
   logic             at_zero;
   logic             expiry;
   logic             fire;

   assign at_zero = (cnt_q == '0);
   assign expiry  = run_i && armed_q && at_zero && !load_i;
   assign fire    = expiry && !hold_i;
   assign quash_o = expiry && hold_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= POR_VAL;
         armed_q <= 1'b0;
      end else if (load_i) begin
         cnt_q   <= load_val_i;
         armed_q <= 1'b1;
      end else if (expiry) begin
         armed_q <= 1'b0;
      end else if (run_i && armed_q && step_i && !at_zero) begin
         cnt_q   <= cnt_q - 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         expire_o   <= 1'b0;
         irq_o      <= 1'b0;
         sysrst_o   <= 1'b0;
         extrst_o   <= 1'b0;
         fullchip_o <= 1'b0;
      end else begin
         expire_o   <= fire;
         irq_o      <= fire && irq_en_i;
         sysrst_o   <= fire && sys_en_i;
         extrst_o   <= fire && ext_en_i;
         fullchip_o <= fire && sys_en_i && full_en_i;
      end
   end

   assign cnt_o   = cnt_q;
   assign armed_o = armed_q;
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
   import wdog_pkg::*;
#(
   parameter int unsigned ADDR_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [DATA_W-1:0] cnt_i,
   input  logic              quash_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic [DATA_W-1:0] reload_o,
   output ctrl_t             ctrl_o,
   output logic              load_o
);
   localparam int unsigned WI_W = ADDR_W - 2;

   if (ADDR_W < 4) begin : g_bad_addr
      $error("wdog_regs: ADDR_W must reach the control word");
   end

   logic            aligned;
   logic [WI_W-1:0] widx;
   logic            hit_count, hit_reload, hit_kick, hit_ctrl;
   logic            kick, ctrl_wr, rise;
   ctrl_t           ctrl_q, ctrl_new;
   logic [DATA_W-1:0] reload_q;

   assign aligned    = (addr_i[1:0] == 2'b00);
   assign widx       = addr_i[ADDR_W-1:2];
   assign hit_count  = aligned && (widx == WI_W'(W_COUNT));
   assign hit_reload = aligned && (widx == WI_W'(W_RELOAD));
   assign hit_kick   = aligned && (widx == WI_W'(W_KICK));
   assign hit_ctrl   = aligned && (widx == WI_W'(W_CTRL));

   assign ctrl_new = ctrl_t'(wdata_i[CTRL_W-1:0]);
   assign kick     = wr_i && hit_kick && (wdata_i[15:0] == KICK_KEY);
   assign ctrl_wr  = wr_i && hit_ctrl;
   assign rise     = ctrl_wr && ctrl_new.enable && !ctrl_q.enable;
   assign load_o   = kick || rise;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (ctrl_wr) begin
         ctrl_q <= ctrl_new;
      end else if (quash_i) begin
         ctrl_q <= '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reload_q <= POR_COUNT;
      end else if (wr_i && hit_reload) begin
         reload_q <= wdata_i;
      end
   end

   always_comb begin
      rdata_o = '0;
      if (hit_count)  rdata_o = cnt_i;
      if (hit_reload) rdata_o = reload_q;
      if (hit_ctrl)   rdata_o = DATA_W'(ctrl_q);
   end

   assign reload_o = reload_q;
   assign ctrl_o   = ctrl_q;
endmodule

// File: rtl/tick_watchdog.sv
module tick_watchdog
   import wdog_pkg::*;
#(
   parameter int unsigned ADDR_W  = 5,
   parameter int unsigned CLK_HZ  = 50_000_000,
   parameter int unsigned TICK_HZ = 1_000_000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic              mem_hold,
   output logic              expire_o,
   output logic              irq_o,
   output logic              sysrst_o,
   output logic              extrst_o,
   output logic              fullchip_o
);
   localparam int unsigned DIV = (TICK_HZ == 0) ? 1 : CLK_HZ / TICK_HZ;

   if (TICK_HZ == 0 || CLK_HZ < TICK_HZ) begin : g_bad_rate
      $error("tick_watchdog: CLK_HZ must be at least TICK_HZ");
   end

   ctrl_t             ctrl;
   logic [DATA_W-1:0] reload_val;
   logic [DATA_W-1:0] cnt_q;
   logic              load, quash, armed_q, ptick, step;
   logic              en_q, sel_q;

   assign en_q  = ctrl.enable;
   assign sel_q = ctrl.tick_slow;
   assign step  = sel_q ? ptick : 1'b1;

   wdog_regs #(.ADDR_W(ADDR_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_i     (bus_wr),
      .addr_i   (bus_addr),
      .wdata_i  (bus_wdata),
      .cnt_i    (cnt_q),
      .quash_i  (quash),
      .rdata_o  (bus_rdata),
      .reload_o (reload_val),
      .ctrl_o   (ctrl),
      .load_o   (load)
   );

   wdog_prescaler #(.DIV(DIV)) u_presc (
      .clk     (clk),
      .rst_n   (rst_n),
      .run_i   (en_q && armed_q && sel_q),
      .clear_i (load),
      .tick_o  (ptick)
   );

   wdog_core #(.CNT_W(DATA_W), .POR_VAL(POR_COUNT)) u_core (
      .clk        (clk),
      .rst_n      (rst_n),
      .run_i      (en_q),
      .step_i     (step),
      .load_i     (load),
      .load_val_i (reload_val),
      .hold_i     (mem_hold),
      .irq_en_i   (ctrl.irq_en),
      .sys_en_i   (ctrl.sys_en),
      .ext_en_i   (ctrl.ext_en),
      .full_en_i  (ctrl.full_chip),
      .cnt_o      (cnt_q),
      .armed_o    (armed_q),
      .quash_o    (quash),
      .expire_o   (expire_o),
      .irq_o      (irq_o),
      .sysrst_o   (sysrst_o),
      .extrst_o   (extrst_o),
      .fullchip_o (fullchip_o)
   );
endmodule

// File: rtl/wdog_checker.sv
module wdog_checker #(
   parameter int unsigned ADDR_W = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              mem_hold,
   input logic              expire_o,
   input logic              irq_o,
   input logic              sysrst_o,
   input logic              extrst_o,
   input logic              fullchip_o,
   input logic [31:0]       cnt_q,
   input logic              en_q,
   input logic              armed_q,
   input logic              sel_q
);
   logic loads_possible;
   assign loads_possible = bus_wr && ((bus_addr == ADDR_W'(8)) || (bus_addr == ADDR_W'(12)));

   p_one_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      expire_o |=> !expire_o);

   p_irq_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> expire_o);

   p_sys_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (sysrst_o || extrst_o) |-> expire_o);

   p_scope_r7: assert property (@(posedge clk) disable iff (!rst_n)
      fullchip_o |-> sysrst_o);

   p_hold_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_hold && !bus_wr) |=> !expire_o);

   p_zero_sticks_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == 32'd0 && !bus_wr) |=> (cnt_q == 32'd0));

   p_fast_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q && armed_q && !sel_q && cnt_q != 32'd0 && !bus_wr) |=> (cnt_q == $past(cnt_q) - 32'd1));

   p_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_q && !loads_possible) |=> $stable(cnt_q));
endmodule

bind tick_watchdog wdog_checker #(.ADDR_W(ADDR_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_wr     (bus_wr),
   .bus_addr   (bus_addr),
   .mem_hold   (mem_hold),
   .expire_o   (expire_o),
   .irq_o      (irq_o),
   .sysrst_o   (sysrst_o),
   .extrst_o   (extrst_o),
   .fullchip_o (fullchip_o),
   .cnt_q      (cnt_q),
   .en_q       (en_q),
   .armed_q    (armed_q),
   .sel_q      (sel_q)
);

// File: tb/test_tick_watchdog.sv
`timescale 1ns/1ps
module test_tick_watchdog;
   localparam int unsigned AW  = 5;
   localparam int unsigned DIV = 50_000_000 / 1_000_000;
   localparam int unsigned NV  = 5;
   // {reload[15:0], ctrl[7:0]}
   localparam logic [23:0] VEC [NV] = '{
      {16'd5, 8'h03}, {16'd0, 8'h07}, {16'd2, 8'h13},
      {16'd9, 8'h2B}, {16'd1, 8'h35}
   };

   logic clk = 1'b0, rst_n = 1'b0;
   logic bus_wr = 1'b0, mem_hold = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0, bus_rdata;
   logic expire_o, irq_o, sysrst_o, extrst_o, fullchip_o;
   int total = 0, bad = 0, cyc = 0;
   logic done = 1'b0;

   always #10 clk = ~clk;

   tick_watchdog #(.ADDR_W(AW)) i_tick_watchdog (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mem_hold(mem_hold),
      .expire_o(expire_o), .irq_o(irq_o), .sysrst_o(sysrst_o),
      .extrst_o(extrst_o), .fullchip_o(fullchip_o)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000 && !done) begin
         bad = bad + 1;
         total = total + 1;
         $display("FAIL watchdog: run hung, act=%0d exp=<150000", cyc);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   // counts negedges after the write edge until expire_o is seen
   task automatic wait_fire(input int limit, output int k);
      k = 0;
      for (int i = 1; i <= limit; i++) begin
         @(negedge clk);
         if (expire_o) begin k = i; break; end
      end
   endtask

   task automatic watch_quiet(input int n, output logic seen);
      seen = 1'b0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (expire_o) seen = 1'b1;
      end
   endtask

   initial begin
      logic [31:0] v, c1;
      int k, expk;
      logic seen;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R8 reset state
      rd(5'h00, v); check("R8 counter", v, 32'h03EF1480);
      rd(5'h04, v); check("R8 reload", v, 32'h03EF1480);
      rd(5'h0C, v); check("R8 ctrl", v, 32'h0);
      check("R8 outputs", {27'd0, expire_o, irq_o, sysrst_o, extrst_o, fullchip_o}, 32'h0);

      // vector table: R3 R5 R6 R7
      for (int n = 0; n < NV; n++) begin
         logic [15:0] rl;
         logic [7:0] ct;
         rl = VEC[n][23:8];
         ct = VEC[n][7:0];
         wr(5'h0C, 32'h0);
         wr(5'h04, {16'd0, rl});
         expk = int'(rl) * (ct[4] ? DIV : 1) + 1;
         wr(5'h0C, {24'd0, ct});
         wait_fire(expk + 20, k);
         check("R6 R5 R3 latency", k, expk);
         check("R7 irq", irq_o, ct[2]);
         check("R7 sysrst", sysrst_o, ct[1]);
         check("R7 extrst", extrst_o, ct[3]);
         check("R7 fullchip", fullchip_o, ct[1] & ct[5]);
         @(negedge clk);
         check("R6 single pulse", expire_o, 1'b0);
      end

      // R10 no rearm, then key rearms (last vector: reload 1, slow tick)
      rd(5'h00, v); check("R10 counter parked", v, 32'h0);
      watch_quiet(30, seen); check("R10 no second pulse", seen, 1'b0);
      wr(5'h08, 32'h0000_4755);
      wait_fire(DIV + 20, k);
      check("R10 R2 key rearms", k, DIV + 1);

      // R2 R1 key matching and register reads
      wr(5'h0C, 32'h0);
      wr(5'h04, 32'd77);
      rd(5'h00, v); check("R1 counter not reload", v, 32'h0);
      wr(5'h08, 32'h0000_1234);
      rd(5'h00, v); check("R2 wrong key ignored", v, 32'h0);
      wr(5'h08, 32'hABCD_4755);
      rd(5'h00, v); check("R2 key loads", v, 32'd77);
      rd(5'h08, v); check("R1 key reads zero", v, 32'h0);
      wr(5'h00, 32'd5);
      rd(5'h00, v); check("R1 counter read-only", v, 32'd77);

      // R4 enable-unchanged write and disable freeze
      wr(5'h04, 32'd200);
      wr(5'h0C, 32'h01);
      repeat (10) @(negedge clk);
      wr(5'h0C, 32'h03);
      rd(5'h0C, v); check("R4 other bits updated", v, 32'h03);
      rd(5'h00, v); check("R4 no reload", (v < 32'd200 && v > 32'd150), 1'b1);
      wr(5'h0C, 32'h02);
      rd(5'h00, c1);
      watch_quiet(20, seen);
      rd(5'h00, v); check("R4 frozen", v, c1);
      check("R4 no pulse when off", seen, 1'b0);

      // R9 memory hold
      wr(5'h0C, 32'h0);
      mem_hold = 1'b1;
      wr(5'h04, 32'd2);
      wr(5'h0C, 32'h0F);
      watch_quiet(12, seen);
      check("R9 no pulse", seen, 1'b0);
      rd(5'h0C, v); check("R9 ctrl cleared", v, 32'h0);
      rd(5'h00, v); check("R9 counter zero", v, 32'h0);
      mem_hold = 1'b0;

      // R11 unmapped / misaligned
      wr(5'h0C, 32'h04);
      wr(5'h10, 32'hFFFF_FFFF);
      wr(5'h14, 32'hFFFF_FFFF);
      wr(5'h0D, 32'h0000_0001);
      wr(5'h05, 32'h0000_1111);
      rd(5'h0C, v); check("R11 ctrl untouched", v, 32'h04);
      rd(5'h04, v); check("R11 reload untouched", v, 32'd2);
      rd(5'h10, v); check("R11 read 0x10", v, 32'h0);
      rd(5'h1C, v); check("R11 read 0x1C", v, 32'h0);
      rd(5'h0D, v); check("R11 misaligned read", v, 32'h0);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule